// File: doc/BRIEF.md
# Banked Floating-Point Register File with Architectural Views

This block holds the single-precision register state of a floating-point unit. It has 32 physical 32-bit words, split into two banks of 16. It performs no arithmetic. Its job is to store the words and to map each architectural name onto a physical word.

Four access shapes reach the same storage:
- a scalar word,
- an even-aligned pair of words,
- a four-word vector,
- the full set of sixteen extended words, read row by row as four vectors.

Each access also names a side. The front side is the normal register names. The extended side is the alternate names. One select bit in the control word decides which physical bank is the front and which is the extended.

A pipeline uses the ports as follows:
- the scalar read and write ports serve single-precision operands;
- the pair port moves 64-bit double values;
- the vector port feeds four-element operations;
- with the extended side chosen, the vector port returns rows of the extended matrix.

All read results are registered. A malformed pair or vector index is reported on an error flag and changes nothing.

Top module: `fprf_banked`

## Requirements
- R1: After reset every physical word reads as zero, the control word reads as zero, the select bit is 0, and no valid or error output is asserted.
- R2: A scalar access with ext=0 addresses bank `sel`, and one with ext=1 addresses bank `~sel`. Index i selects word i of that bank.
- R3: A scalar read returns its data with `sr_valid` high exactly one cycle after the request. A read and a write of the same word in the same cycle return the value held before the write.
- R4: A pair access with an even index n covers words n and n+1 of the chosen side. Word n is bits [63:32] and word n+1 is bits [31:0], for both read and write.
- R5: A vector read with index n in {0,4,8,12} returns words n..n+3 of the chosen side, word n in bits [127:96] down to word n+3 in bits [31:0]. With ext=1 the four indices together return all sixteen extended words (the matrix view).
- R6: A pair access with an odd index, or a vector read whose index is not a multiple of 4, raises `err_o` for one cycle, one cycle after the request. It produces no valid output and writes nothing.
- R7: A control write stores the full 32-bit word, readable on `ctl_rdata`. Only bit 21 acts as the select bit, and the other bits have no effect on the mapping. A new select value applies to accesses from the cycle after the write; accesses in the same cycle as the write still use the old value.
- R8: When a scalar write and a pair write hit the same physical word in one cycle, the word takes the pair data. When they hit different words, both writes take effect.
- R9: The scalar, pair and vector ports operate independently in the same cycle, and each returns its own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data (bit 21 = select) |
| ctl_rdata | output | 32 | Stored control word |
| sel_o | output | 1 | Current select bit |
| sr_en | input | 1 | Scalar read request |
| sr_ext | input | 1 | Scalar read side (0 front, 1 extended) |
| sr_idx | input | 4 | Scalar read index |
| sr_data | output | 32 | Scalar read data |
| sr_valid | output | 1 | Scalar read data valid |
| sw_en | input | 1 | Scalar write request |
| sw_ext | input | 1 | Scalar write side |
| sw_idx | input | 4 | Scalar write index |
| sw_data | input | 32 | Scalar write data |
| pr_en | input | 1 | Pair access request |
| pr_we | input | 1 | Pair access is a write |
| pr_ext | input | 1 | Pair side |
| pr_idx | input | 4 | Pair index (must be even) |
| pr_wdata | input | 64 | Pair write data |
| pr_rdata | output | 64 | Pair read data |
| pr_valid | output | 1 | Pair read data valid |
| vr_en | input | 1 | Vector read request |
| vr_ext | input | 1 | Vector side (1 = matrix row) |
| vr_idx | input | 4 | Vector index (multiple of 4) |
| vr_data | output | 128 | Vector read data |
| vr_valid | output | 1 | Vector read data valid |
| err_o | output | 1 | Misaligned access flag |

## Verification
Two situations can occur in the same cycle and are provoked directly.

The first is a scalar write and a pair write that land on the same physical word. The bench issues them together, on both the even and the odd half of a pair. It then reads the word back and expects the pair value. It also issues a non-overlapping combination and expects both values to land.

The second is a control write that flips the select bit in the same cycle as reads and writes. The bench expects those accesses to resolve against the old bank, and the following cycle's accesses to resolve against the new one.

A scoreboard holds one expected item per request, tagged with its due cycle. A missing response, an extra response or a wrong value each counts as a failure.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned FPRF_WORD_W   = 32;
  localparam int unsigned FPRF_BANK_SZ  = 16;
  localparam int unsigned FPRF_CTL_W    = 32;
  localparam int unsigned FPRF_SEL_BIT  = 21;

  // true when idx is a legal base for an access spanning `lanes` words
  function automatic logic base_ok(input int idx, input int lanes);
    return (idx % lanes) == 0;
  endfunction
endpackage

// File: rtl/fprf_ctl_reg.sv
module fprf_ctl_reg #(
  parameter int unsigned CTL_W   = fprf_pkg::FPRF_CTL_W,
  parameter int unsigned SEL_BIT = fprf_pkg::FPRF_SEL_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] word_o,
  output logic             sel_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign word_o = ctl_q;
  assign sel_o  = ctl_q[SEL_BIT];

  // R7: the select bit only moves on a control write
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(sel_o));
  // R7: a control write lands on the next cycle
  p_sel_load_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> sel_o == $past(wdata[SEL_BIT]));
endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int unsigned W   = fprf_pkg::FPRF_WORD_W,
  parameter int unsigned NPB = fprf_pkg::FPRF_BANK_SZ
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         s_we,
  input  logic [$clog2(2*NPB)-1:0]     s_addr,
  input  logic [W-1:0]                 s_data,
  input  logic                         p_we,
  input  logic [$clog2(2*NPB)-1:0]     p_addr,
  input  logic [2*W-1:0]               p_data,
  output logic [2*NPB-1:0][W-1:0]      regs_o
);
  localparam int unsigned NR = 2 * NPB;
  localparam int unsigned PW = $clog2(NR);

  logic [NR-1:0][W-1:0] mem_q;
  logic [PW-1:0]        p_addr_lo;

  assign p_addr_lo = p_addr + PW'(1);

  // one register per physical word; pair halves outrank the scalar write
  for (genvar e = 0; e < NR; e++) begin : g_word
    logic hit_s, hit_hi, hit_lo;
    assign hit_s  = s_we && (s_addr    == PW'(e));
    assign hit_hi = p_we && (p_addr    == PW'(e));
    assign hit_lo = p_we && (p_addr_lo == PW'(e));

    always_ff @(posedge clk) begin
      if (rst)         mem_q[e] <= '0;
      else if (hit_hi) mem_q[e] <= p_data[2*W-1:W];
      else if (hit_lo) mem_q[e] <= p_data[W-1:0];
      else if (hit_s)  mem_q[e] <= s_data;
    end
  end

  assign regs_o = mem_q;

  // R4: pair writes only ever arrive on an even base
  p_pair_even_r4: assert property (@(posedge clk) disable iff (rst)
    p_we |-> !p_addr[0]);
  // R8: overlapping scalar and pair writes leave the pair value
  p_pair_beats_scalar_r8: assert property (@(posedge clk) disable iff (rst)
    (s_we && p_we && (s_addr[PW-1:1] == p_addr[PW-1:1])) |=>
      mem_q[$past(s_addr)] == ($past(s_addr[0]) ? $past(p_data[W-1:0])
                                                 : $past(p_data[2*W-1:W])));
  // R6: nothing changes without a write strobe
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!s_we && !p_we) |=> $stable(mem_q));
endmodule

// File: rtl/fprf_view_port.sv
module fprf_view_port #(
  parameter int unsigned W     = fprf_pkg::FPRF_WORD_W,
  parameter int unsigned NPB   = fprf_pkg::FPRF_BANK_SZ,
  parameter int unsigned LANES = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel,
  input  logic                      req,
  input  logic                      rd,
  input  logic                      ext,
  input  logic [$clog2(NPB)-1:0]    idx,
  input  logic [2*NPB-1:0][W-1:0]   regs,
  output logic [LANES*W-1:0]        data_o,
  output logic                      valid_o,
  output logic                      err_o
);
  localparam int unsigned IW = $clog2(NPB);

  logic                 aligned, bank, take;
  logic [LANES*W-1:0]   gather;

  assign aligned = fprf_pkg::base_ok(int'(idx), int'(LANES));
  assign bank    = ext ^ sel;
  assign take    = req && rd && aligned;

  // lowest-numbered word goes to the most significant lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] li;
    assign li = idx + IW'(k);
    assign gather[(LANES-1-k)*W +: W] = regs[{bank, li}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= take;
      err_o   <= req && !aligned;
      if (take) data_o <= gather;
    end
  end

  // R6: a misaligned request yields one error and no data
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (req && !aligned) |=> (err_o && !valid_o));
  // R3: an accepted read is answered on the next cycle
  p_valid_next_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (valid_o && !err_o));
  // R3: read data is held while no read is issued
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(req && rd) |=> $stable(data_o));
endmodule

// File: rtl/fprf_banked.sv
module fprf_banked #(
  parameter int unsigned W       = fprf_pkg::FPRF_WORD_W,
  parameter int unsigned NPB     = fprf_pkg::FPRF_BANK_SZ,
  parameter int unsigned CTL_W   = fprf_pkg::FPRF_CTL_W,
  parameter int unsigned SEL_BIT = fprf_pkg::FPRF_SEL_BIT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_we,
  input  logic [CTL_W-1:0]        ctl_wdata,
  output logic [CTL_W-1:0]        ctl_rdata,
  output logic                    sel_o,
  input  logic                    sr_en,
  input  logic                    sr_ext,
  input  logic [$clog2(NPB)-1:0]  sr_idx,
  output logic [W-1:0]            sr_data,
  output logic                    sr_valid,
  input  logic                    sw_en,
  input  logic                    sw_ext,
  input  logic [$clog2(NPB)-1:0]  sw_idx,
  input  logic [W-1:0]            sw_data,
  input  logic                    pr_en,
  input  logic                    pr_we,
  input  logic                    pr_ext,
  input  logic [$clog2(NPB)-1:0]  pr_idx,
  input  logic [2*W-1:0]          pr_wdata,
  output logic [2*W-1:0]          pr_rdata,
  output logic                    pr_valid,
  input  logic                    vr_en,
  input  logic                    vr_ext,
  input  logic [$clog2(NPB)-1:0]  vr_idx,
  output logic [4*W-1:0]          vr_data,
  output logic                    vr_valid,
  output logic                    err_o
);
  localparam int unsigned NR = 2 * NPB;
  localparam int unsigned PW = $clog2(NR);

  logic                 sel;
  logic [NR-1:0][W-1:0] regs;
  logic [PW-1:0]        s_addr, p_addr;
  logic                 p_write_ok;
  logic                 err_s, err_p, err_v;

  fprf_ctl_reg #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .word_o(ctl_rdata), .sel_o(sel)
  );
  assign sel_o = sel;

  // logical side and index to physical word, using the select in force now
  assign s_addr     = {sw_ext ^ sel, sw_idx};
  assign p_addr     = {pr_ext ^ sel, pr_idx};
  assign p_write_ok = pr_en && pr_we && fprf_pkg::base_ok(int'(pr_idx), 2);

  fprf_store #(.W(W), .NPB(NPB)) u_store (
    .clk(clk), .rst(rst),
    .s_we(sw_en), .s_addr(s_addr), .s_data(sw_data),
    .p_we(p_write_ok), .p_addr(p_addr), .p_data(pr_wdata),
    .regs_o(regs)
  );

  fprf_view_port #(.W(W), .NPB(NPB), .LANES(1)) u_scalar (
    .clk(clk), .rst(rst), .sel(sel), .req(sr_en), .rd(1'b1),
    .ext(sr_ext), .idx(sr_idx), .regs(regs),
    .data_o(sr_data), .valid_o(sr_valid), .err_o(err_s)
  );

  fprf_view_port #(.W(W), .NPB(NPB), .LANES(2)) u_pair (
    .clk(clk), .rst(rst), .sel(sel), .req(pr_en), .rd(!pr_we),
    .ext(pr_ext), .idx(pr_idx), .regs(regs),
    .data_o(pr_rdata), .valid_o(pr_valid), .err_o(err_p)
  );

  fprf_view_port #(.W(W), .NPB(NPB), .LANES(4)) u_vector (
    .clk(clk), .rst(rst), .sel(sel), .req(vr_en), .rd(1'b1),
    .ext(vr_ext), .idx(vr_idx), .regs(regs),
    .data_o(vr_data), .valid_o(vr_valid), .err_o(err_v)
  );

  assign err_o = err_s | err_p | err_v;

  // R6: a misaligned pair write never reaches the store
  p_bad_pair_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (pr_en && pr_we && pr_idx[0]) |=> err_o);
endmodule

// File: tb/fprf_banked_tb_top.sv
module fprf_banked_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic ctl_we; logic [31:0] ctl_wdata, ctl_rdata; logic sel_o;
  logic sr_en, sr_ext; logic [3:0] sr_idx; logic [31:0] sr_data; logic sr_valid;
  logic sw_en, sw_ext; logic [3:0] sw_idx; logic [31:0] sw_data;
  logic pr_en, pr_we, pr_ext; logic [3:0] pr_idx; logic [63:0] pr_wdata, pr_rdata; logic pr_valid;
  logic vr_en, vr_ext; logic [3:0] vr_idx; logic [127:0] vr_data; logic vr_valid;
  logic err_o;

  fprf_banked dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sel_o(sel_o),
    .sr_en(sr_en), .sr_ext(sr_ext), .sr_idx(sr_idx), .sr_data(sr_data), .sr_valid(sr_valid),
    .sw_en(sw_en), .sw_ext(sw_ext), .sw_idx(sw_idx), .sw_data(sw_data),
    .pr_en(pr_en), .pr_we(pr_we), .pr_ext(pr_ext), .pr_idx(pr_idx),
    .pr_wdata(pr_wdata), .pr_rdata(pr_rdata), .pr_valid(pr_valid),
    .vr_en(vr_en), .vr_ext(vr_ext), .vr_idx(vr_idx), .vr_data(vr_data), .vr_valid(vr_valid),
    .err_o(err_o)
  );

  typedef struct { logic [127:0] data; int due; string tag; } exp_t;
  exp_t qs[$], qp[$], qv[$], qe[$];

  logic [31:0] model [2][16];
  logic        msel;
  logic [31:0] mctl;
  int total = 0, bad = 0, cycnt = 0;
  bit done = 0;

  always @(posedge clk) cycnt++;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop the item due this cycle, or flag an unexpected response
  task automatic mon(ref exp_t q[$], input logic v, input logic [127:0] d, input string extra);
    if (q.size() > 0 && q[0].due == cycnt) begin
      if (!v) begin
        total++; bad++;
        $display("FAIL %s missing response act=0 exp=1", q[0].tag);
      end else chk(q[0].tag, d, q[0].data);
      void'(q.pop_front());
    end else if (v) begin
      total++; bad++;
      $display("FAIL %s unexpected response act=1 exp=0", extra);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    mon(qs, sr_valid, {96'b0, sr_data}, "R3 scalar");
    mon(qp, pr_valid, {64'b0, pr_rdata}, "R4 pair");
    mon(qv, vr_valid, vr_data, "R5 vector");
    mon(qe, err_o, 128'b0, "R6 error");
  end

  task automatic idle();
    ctl_we = 0; ctl_wdata = '0;
    sr_en = 0; sr_ext = 0; sr_idx = '0;
    sw_en = 0; sw_ext = 0; sw_idx = '0; sw_data = '0;
    pr_en = 0; pr_we = 0; pr_ext = 0; pr_idx = '0; pr_wdata = '0;
    vr_en = 0; vr_ext = 0; vr_idx = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  // reads must be set before writes of the same cycle; control write last
  task automatic rd_s(bit ext, int idx, string tag);
    sr_en = 1; sr_ext = ext; sr_idx = 4'(idx);
    qs.push_back('{{96'b0, model[ext ^ msel][idx]}, cycnt + 1, tag});
  endtask

  task automatic wr_s(bit ext, int idx, logic [31:0] d);
    sw_en = 1; sw_ext = ext; sw_idx = 4'(idx); sw_data = d;
    model[ext ^ msel][idx] = d;
  endtask

  task automatic rd_p(bit ext, int idx, string tag);
    pr_en = 1; pr_we = 0; pr_ext = ext; pr_idx = 4'(idx);
    if (idx % 2 != 0) qe.push_back('{128'b0, cycnt + 1, tag});
    else qp.push_back('{{64'b0, model[ext ^ msel][idx], model[ext ^ msel][idx + 1]},
                        cycnt + 1, tag});
  endtask

  task automatic wr_p(bit ext, int idx, logic [63:0] d, string tag);
    pr_en = 1; pr_we = 1; pr_ext = ext; pr_idx = 4'(idx); pr_wdata = d;
    if (idx % 2 != 0) qe.push_back('{128'b0, cycnt + 1, tag});
    else begin
      model[ext ^ msel][idx]     = d[63:32];
      model[ext ^ msel][idx + 1] = d[31:0];
    end
  endtask

  task automatic rd_v(bit ext, int idx, string tag);
    vr_en = 1; vr_ext = ext; vr_idx = 4'(idx);
    if (idx % 4 != 0) qe.push_back('{128'b0, cycnt + 1, tag});
    else qv.push_back('{{model[ext ^ msel][idx], model[ext ^ msel][idx + 1],
                         model[ext ^ msel][idx + 2], model[ext ^ msel][idx + 3]},
                        cycnt + 1, tag});
  endtask

  task automatic set_ctl(logic [31:0] w);
    ctl_we = 1; ctl_wdata = w; msel = w[21]; mctl = w;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1; msel = 0; mctl = '0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 16; i++) model[b][i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1: reset state
    chk("R1 sel after reset", {127'b0, sel_o}, 128'b0);
    chk("R1 ctl after reset", {96'b0, ctl_rdata}, 128'b0);
    chk("R1 no outputs after reset", {124'b0, sr_valid, pr_valid, vr_valid, err_o}, 128'b0);
    rd_s(0, 0, "R1 FR0 zero"); rd_p(1, 14, "R1 XD14 zero"); rd_v(1, 12, "R1 matrix row zero");
    step();

    // R2: fill both sides with distinct values
    for (int i = 0; i < 16; i++) begin wr_s(0, i, 32'h1000_0000 + i); step(); end
    for (int i = 0; i < 16; i++) begin wr_s(1, i, 32'h2000_0000 + i); step(); end
    rd_s(0, 3, "R2 FR3 in bank0"); step();
    rd_s(1, 7, "R2 XF7 in bank1"); step();

    // R3: read-during-write returns the old value, next read the new one
    rd_s(0, 5, "R3 read during write old"); wr_s(0, 5, 32'hCAFE_0005); step();
    rd_s(0, 5, "R3 read after write new"); step();

    // R4: pair views
    rd_p(0, 4, "R4 DR4 pair order"); step();
    rd_p(1, 6, "R4 XD6 pair order"); step();
    wr_p(0, 8, 64'hAAAA_0008_BBBB_0009, "R4 DR8 write"); step();
    rd_s(0, 8, "R4 FR8 holds upper half"); step();
    rd_s(0, 9, "R4 FR9 holds lower half"); step();

    // R5: vector and matrix views
    rd_v(0, 4, "R5 FV4 order"); step();
    for (int n = 0; n < 16; n += 4) begin rd_v(1, n, "R5 matrix row"); step(); end

    // R6: misaligned accesses flag and change nothing
    rd_p(0, 3, "R6 odd pair read err"); step();
    wr_p(0, 5, 64'hDEAD_DEAD_DEAD_DEAD, "R6 odd pair write err"); step();
    rd_s(0, 5, "R6 FR5 unchanged"); step();
    rd_s(0, 6, "R6 FR6 unchanged"); step();
    rd_v(1, 6, "R6 vector misaligned err"); step();

    // R7: select flip applies next cycle; same-cycle access uses old bank
    rd_s(0, 0, "R7 same-cycle read old bank"); set_ctl(32'h0020_0000); step();
    chk("R7 sel set", {127'b0, sel_o}, 128'b1);
    rd_s(0, 0, "R7 FR0 now bank1"); step();
    rd_s(1, 0, "R7 XF0 now bank0"); step();
    wr_s(0, 2, 32'h5555_0002); step();
    set_ctl(32'hFFDF_FFFF); step();
    chk("R7 other bits ignored sel", {127'b0, sel_o}, 128'b0);
    chk("R7 ctl word stored", {96'b0, ctl_rdata}, {96'b0, mctl});
    rd_s(1, 2, "R7 write under sel1 landed in bank1"); step();
    rd_s(0, 2, "R7 bank0 FR2 untouched"); step();

    // R8: overlapping scalar and pair writes
    wr_s(0, 10, 32'h0BAD_000A); wr_p(0, 10, 64'h7777_000A_7777_000B, "R8 overlap even"); step();
    rd_p(0, 10, "R8 pair wins on even word"); step();
    wr_s(1, 11, 32'h0BAD_000B); wr_p(1, 10, 64'h6666_000A_6666_000B, "R8 overlap odd"); step();
    rd_p(1, 10, "R8 pair wins on odd word"); step();
    wr_s(0, 13, 32'h3333_000D); wr_p(0, 0, 64'h4444_0000_4444_0001, "R8 disjoint"); step();
    rd_s(0, 13, "R8 disjoint scalar kept"); step();
    rd_p(0, 0, "R8 disjoint pair kept"); step();

    // R9: all three ports in one cycle, plus a write elsewhere
    rd_s(1, 9, "R9 scalar concurrent"); rd_p(0, 12, "R9 pair concurrent");
    rd_v(1, 8, "R9 vector concurrent"); wr_s(0, 15, 32'h9999_000F); step();
    rd_v(0, 12, "R9 vector after write"); step();

    repeat (4) step();
    chk("R9 all responses drained", 128'(qs.size() + qp.size() + qv.size() + qe.size()), 128'b0);
    done = 1;
    summary();
    $finish;
  end
endmodule